// File: doc/BRIEF.md
# Banked Data Pointer Modifier

This block holds the two address pointers of a small signal processor. One is an 8-bit data RAM pointer and the other is a 10-bit coefficient ROM pointer. Each arithmetic-class instruction asserts a one-cycle enable strobe, and on that strobe the block post-modifies the pointers.

The RAM pointer is treated as a high bank nibble above a low 4-bit index. The index can stay as it is, step up, step down, or be cleared. A step up or down wraps inside the 4-bit index and never carries into the bank. After that, a 4-bit mask is XORed into the bank nibble. The ROM pointer can be stepped down by one.

The instruction's move field can also name a pointer as its destination. In that case the pointer takes the moved value, and its own modification is dropped for that instruction. The other pointer is still modified as usual.

Top module: `dptr_mod`

## Requirements
- R1: While rst_ni is low, dp_o and rp_o are zero.
- R2: On a clock edge with en_i low, dp_o and rp_o keep their values.
- R3: With en_i high and dst_i not 4, low_mode_i = 0 leaves dp_o[3:0] unchanged.
- R4: With en_i high and dst_i not 4, low_mode_i = 1 adds one to dp_o[3:0] modulo 16, with no carry into bit 4 (0xF becomes 0x0).
- R5: With en_i high and dst_i not 4, low_mode_i = 2 subtracts one from dp_o[3:0] modulo 16, with no borrow from bit 4 (0x0 becomes 0xF).
- R6: With en_i high and dst_i not 4, low_mode_i = 3 sets dp_o[3:0] to zero.
- R7: With en_i high and dst_i not 4, the new dp_o[7:4] is the old dp_o[7:4] XOR hi_mask_i, for every low_mode_i value.
- R8: With en_i high and dst_i = 4, dp_o becomes load_i[7:0], and low_mode_i and hi_mask_i have no effect.
- R9: With en_i high, dst_i not 5 and rp_dec_i high, rp_o decreases by one modulo 1024 (0 becomes 0x3FF). With rp_dec_i low, rp_o is unchanged.
- R10: With en_i high and dst_i = 5, rp_o becomes load_i[9:0], and rp_dec_i has no effect.
- R11: A destination code other than 4 or 5 loads neither pointer. Loading one pointer does not suppress the modification of the other.
- R12: Results appear on dp_o and rp_o one clock edge after the enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Update strobe, one per arithmetic instruction |
| low_mode_i | input | 2 | Index modify: 0 keep, 1 step up, 2 step down, 3 clear |
| hi_mask_i | input | 4 | XOR mask applied to the bank nibble |
| rp_dec_i | input | 1 | Decrement request for the ROM pointer |
| dst_i | input | 4 | Move destination code (4 = RAM pointer, 5 = ROM pointer) |
| load_i | input | 16 | Value carried by the move |
| dp_o | output | 8 | RAM pointer |
| rp_o | output | 10 | ROM pointer |

## Verification
The index modes are each driven at both ends of the 4-bit range. Step up from 0xF and step down from 0x0 show whether a carry or borrow leaks into the bank nibble. Nonzero masks are combined with each mode, which separates the XOR stage from the index stage and shows the order in which they apply. Loads are sent together with active modify fields and a set decrement bit. This shows whether the load wins and whether only its own pointer is held back. A strobe-low cycle with every field active shows whether the enable gates both pointers.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
  localparam int DST_W = 4;
  localparam logic [DST_W-1:0] DST_DP = 4'd4;
  localparam logic [DST_W-1:0] DST_RP = 4'd5;

  typedef enum logic [1:0] {
    LOW_KEEP = 2'd0,
    LOW_INC  = 2'd1,
    LOW_DEC  = 2'd2,
    LOW_CLR  = 2'd3
  } low_mode_e;
endpackage

// File: rtl/dptr_dp_unit.sv
module dptr_dp_unit
  import dptr_pkg::*;
#(
  parameter int DP_W  = 8,
  parameter int LOW_W = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  low_mode_e             low_mode_i,
  input  logic [DP_W-LOW_W-1:0] hi_mask_i,
  input  logic                  load_en_i,
  input  logic [DP_W-1:0]       load_i,
  output logic [DP_W-1:0]       dp_o
);
  localparam int HI_W = DP_W - LOW_W;
  typedef logic [LOW_W-1:0] low_t;
  typedef logic [HI_W-1:0]  hi_t;

  logic [DP_W-1:0] dp_q, dp_d;
  low_t low_d;

  always_comb begin
    case (low_mode_i)
      LOW_INC: low_d = dp_q[LOW_W-1:0] + low_t'(1);
      LOW_DEC: low_d = dp_q[LOW_W-1:0] - low_t'(1);
      LOW_CLR: low_d = '0;
      default: low_d = dp_q[LOW_W-1:0];
    endcase
    dp_d = load_en_i ? load_i : {dp_q[DP_W-1:LOW_W] ^ hi_mask_i, low_d};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   dp_q <= '0;
    else if (en_i) dp_q <= dp_d;
  end

  assign dp_o = dp_q;

  a_r2_dp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(dp_o));
  a_r4_low_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !load_en_i && low_mode_i == LOW_INC |=>
      dp_o[LOW_W-1:0] == low_t'($past(dp_o[LOW_W-1:0]) + low_t'(1)));
  a_r5_low_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !load_en_i && low_mode_i == LOW_DEC |=>
      dp_o[LOW_W-1:0] == low_t'($past(dp_o[LOW_W-1:0]) - low_t'(1)));
  a_r6_low_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !load_en_i && low_mode_i == LOW_CLR |=> dp_o[LOW_W-1:0] == '0);
  a_r7_hi_xor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !load_en_i |=>
      dp_o[DP_W-1:LOW_W] == hi_t'($past(dp_o[DP_W-1:LOW_W]) ^ $past(hi_mask_i)));
  a_r8_dp_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && load_en_i |=> dp_o == $past(load_i));
endmodule

// File: rtl/dptr_rp_unit.sv
module dptr_rp_unit #(
  parameter int RP_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            dec_i,
  input  logic            load_en_i,
  input  logic [RP_W-1:0] load_i,
  output logic [RP_W-1:0] rp_o
);
  typedef logic [RP_W-1:0] rp_t;
  rp_t rp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rp_q <= '0;
    else if (en_i) begin
      if (load_en_i)    rp_q <= load_i;
      else if (dec_i)   rp_q <= rp_q - rp_t'(1);
    end
  end

  assign rp_o = rp_q;

  a_r2_rp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(rp_o));
  a_r9_rp_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !load_en_i && dec_i |=> rp_o == rp_t'($past(rp_o) - rp_t'(1)));
  a_r9_rp_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !load_en_i && !dec_i |=> $stable(rp_o));
  a_r10_rp_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && load_en_i |=> rp_o == $past(load_i));
endmodule

// File: rtl/dptr_mod.sv
module dptr_mod
  import dptr_pkg::*;
#(
  parameter int DP_W   = 8,
  parameter int LOW_W  = 4,
  parameter int RP_W   = 10,
  parameter int LOAD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [1:0]        low_mode_i,
  input  logic [DP_W-LOW_W-1:0] hi_mask_i,
  input  logic              rp_dec_i,
  input  logic [DST_W-1:0]  dst_i,
  input  logic [LOAD_W-1:0] load_i,
  output logic [DP_W-1:0]   dp_o,
  output logic [RP_W-1:0]   rp_o
);
  localparam int MAX_W = (DP_W > RP_W) ? DP_W : RP_W;

  logic dp_load, rp_load;
  logic unused_load;

  assign dp_load     = (dst_i == DST_DP);
  assign rp_load     = (dst_i == DST_RP);
  assign unused_load = ^load_i[LOAD_W-1:MAX_W];

  dptr_dp_unit #(.DP_W(DP_W), .LOW_W(LOW_W)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .low_mode_i (low_mode_e'(low_mode_i)),
    .hi_mask_i  (hi_mask_i),
    .load_en_i  (dp_load),
    .load_i     (load_i[DP_W-1:0]),
    .dp_o       (dp_o)
  );

  dptr_rp_unit #(.RP_W(RP_W)) u_rp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .dec_i     (rp_dec_i),
    .load_en_i (rp_load),
    .load_i    (load_i[RP_W-1:0]),
    .rp_o      (rp_o)
  );

  // R11: a load of one pointer leaves the other on its modify path
  a_r11_dp_not_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && rp_load && low_mode_i == 2'd3 |=> dp_o[LOW_W-1:0] == '0);
  a_r1_reset_zero: assert property (@(posedge clk_i)
    !rst_ni |-> dp_o == '0 && rp_o == '0);
endmodule

// File: tb/dptr_mod_tb.sv
`timescale 1ns/1ps
module dptr_mod_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [1:0]  low_mode_i = '0;
  logic [3:0]  hi_mask_i = '0;
  logic        rp_dec_i = 1'b0;
  logic [3:0]  dst_i = '0;
  logic [15:0] load_i = '0;
  logic [7:0]  dp_o;
  logic [9:0]  rp_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dptr_mod u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .low_mode_i(low_mode_i),
    .hi_mask_i(hi_mask_i), .rp_dec_i(rp_dec_i), .dst_i(dst_i),
    .load_i(load_i), .dp_o(dp_o), .rp_o(rp_o)
  );

  task automatic check(string req, logic [7:0] edp, logic [9:0] erp);
    checks++;
    if (dp_o !== edp || rp_o !== erp) begin
      errors++;
      $display("FAIL %s dp=%h rp=%h expected dp=%h rp=%h", req, dp_o, rp_o, edp, erp);
    end
  endtask

  // drive at negedge, one enabled edge, sample at following negedge (R12)
  task automatic step(logic en, logic [1:0] mode, logic [3:0] mask, logic dec,
                      logic [3:0] dst, logic [15:0] val,
                      string req, logic [7:0] edp, logic [9:0] erp);
    @(negedge clk);
    en_i = en; low_mode_i = mode; hi_mask_i = mask; rp_dec_i = dec;
    dst_i = dst; load_i = val;
    @(negedge clk);
    en_i = 1'b0;
    check(req, edp, erp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1", 8'h00, 10'h000);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1", 8'h00, 10'h000);
  endtask

  task automatic t_loads;
    // R8 mode/mask ignored; R9 rp wraps 0->3FF; R11 dst4 keeps rp path
    step(1, 2'd1, 4'hF, 1, 4'd4, 16'h03AE, "R8_R9_R11", 8'hAE, 10'h3FF);
    // R10 dec ignored; R11 dp still modified (inc)
    step(1, 2'd1, 4'h0, 1, 4'd5, 16'hF155, "R10_R11", 8'hAF, 10'h155);
    // R11 other destination: no load, both modified
    step(1, 2'd0, 4'h0, 1, 4'd7, 16'h1234, "R11", 8'hAF, 10'h154);
    step(1, 2'd0, 4'h0, 0, 4'd0, 16'hFFFF, "R9_keep", 8'hAF, 10'h154);
  endtask

  task automatic t_index;
    step(1, 2'd1, 4'h0, 0, 4'd0, 16'h0, "R4_wrap", 8'hA0, 10'h154);
    step(1, 2'd2, 4'h0, 0, 4'd0, 16'h0, "R5_wrap", 8'hAF, 10'h154);
    step(1, 2'd2, 4'h0, 0, 4'd0, 16'h0, "R5", 8'hAE, 10'h154);
    step(1, 2'd3, 4'h0, 0, 4'd0, 16'h0, "R6", 8'hA0, 10'h154);
  endtask

  task automatic t_mask;
    step(1, 2'd0, 4'h5, 0, 4'd0, 16'h0, "R3_R7", 8'hF0, 10'h154);
    step(1, 2'd1, 4'h3, 0, 4'd0, 16'h0, "R7_inc", 8'hC1, 10'h154);
    step(1, 2'd2, 4'hC, 0, 4'd1, 16'h0, "R7_dec", 8'h00, 10'h154);
    step(1, 2'd2, 4'h9, 0, 4'd0, 16'h0, "R5_R7", 8'h9F, 10'h154);
    step(1, 2'd3, 4'hF, 0, 4'd0, 16'h0, "R6_R7", 8'h60, 10'h154);
  endtask

  task automatic t_hold;
    step(0, 2'd1, 4'hF, 1, 4'd4, 16'h0321, "R2", 8'h60, 10'h154);
    step(0, 2'd3, 4'h1, 1, 4'd5, 16'h0000, "R2", 8'h60, 10'h154);
  endtask

  task automatic t_rp_wrap;
    step(1, 2'd0, 4'h0, 0, 4'd5, 16'h0000, "R10", 8'h60, 10'h000);
    step(1, 2'd0, 4'h0, 1, 4'd0, 16'h0000, "R9_wrap", 8'h60, 10'h3FF);
  endtask

  initial begin
    t_reset();
    t_loads();
    t_index();
    t_mask();
    t_hold();
    t_rp_wrap();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog dp=%h rp=%h expected run to complete", dp_o, rp_o);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule